// File: doc/BRIEF.md
# Dual-Clock FIFO with Arbitrary Depth

This block carries data words from a producer clocked by `wr_clk` to a consumer clocked by an unrelated `rd_clk`. It holds up to `DEPTH` words, and `DEPTH` may be any integer of two or more, including values that are not powers of two. The producer offers a word with `wr_valid` and the word is taken on a `wr_clk` edge where `wr_ready` is high. The consumer sees the oldest stored word on `rd_data` while `rd_valid` is high, and removes it with `rd_ready`.

Each side keeps a position counter running from 0 to 2·DEPTH−1 and then wrapping to 0. Next to the counter it keeps a registered copy of a reflected code of that position. The code has ceil(log2 DEPTH)+1 bits. Positions below DEPTH use the usual binary-to-reflected mapping. The upper half of the sequence is the lower half XORed with a constant K, where K is the code of position DEPTH−1 with its top bit set.

Only the registered code crosses into the other domain, through a two-flop synchronizer. The read side reports emptiness when its own code equals the synchronized write code. The write side reports fullness when its own code XORed with the synchronized read code equals K.

Each side's status is a two-state enumeration, evaluated from the pointer comparison on every cycle:

- Write side, state `SIDE_OPEN`: `wr_ready` is high and a valid word is taken. It moves to `SIDE_BLOCKED` when the codes show the FIFO full.
- Write side, state `SIDE_BLOCKED`: writes are refused. It returns to `SIDE_OPEN` once the advanced read code has been synchronized.
- Read side, state `SIDE_BLOCKED`: this is the empty state, and read requests are ignored. It moves to `SIDE_OPEN` once a new write code has been synchronized.
- Read side, state `SIDE_OPEN`: `rd_valid` is high. It returns to `SIDE_BLOCKED` when the read code catches up with the synchronized write code.

Top module: `xdom_fifo`

## Requirements
- R1: After both `wr_rst_n` and `rd_rst_n` have been low (active-low, asynchronous assertion), `wr_ready` is 1 and `rd_valid` is 0.
- R2: Each pointer code changes in exactly one bit on every step, including the step from position DEPTH−1 to DEPTH and the wrap from 2·DEPTH−1 to 0.
- R3: With no reads, exactly DEPTH words are accepted, and `wr_ready` is then 0.
- R4: A word offered while `wr_ready` is 0 is not stored and does not move the write pointer. After the FIFO is drained, no extra word appears.
- R5: A read request while `rd_valid` is 0 is ignored. The next word written is the next word read.
- R6: Words leave in the order they were accepted, with no loss or duplication. This holds at every fill level from 1 to DEPTH and across many wraps of the 2·DEPTH position range.
- R7: A word written into an empty FIFO does not make `rd_valid` high before the write pointer has passed two `rd_clk` stages. It is visible by the third `rd_clk` edge after the write edge.
- R8: After a read from a full FIFO, `wr_ready` stays 0 until the read pointer has passed two `wr_clk` stages. It is 1 by the third `wr_clk` edge after the read edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| wr_rst_n | input | 1 | Write-domain reset, active low |
| wr_data | input | DATA_W | Word offered by the producer |
| wr_valid | input | 1 | Producer offers `wr_data` |
| wr_ready | output | 1 | FIFO not full; an offered word is taken this edge |
| rd_clk | input | 1 | Read-domain clock |
| rd_rst_n | input | 1 | Read-domain reset, active low |
| rd_data | output | DATA_W | Oldest stored word |
| rd_valid | output | 1 | FIFO not empty; `rd_data` is meaningful |
| rd_ready | input | 1 | Consumer takes the word on `rd_data` this edge |

## Verification
The embedded properties check three things on every cycle of each domain:

- every pointer advance flips exactly one code bit;
- a refused write or read leaves its position counter untouched;
- the position never leaves the range 0 to 2·DEPTH−1.

Capacity, data ordering, and the latency from a write to `rd_valid` (and from a read back to `wr_ready`) span both clock domains. Only the bench scenarios show these. The bench sweeps every fill level, wraps the pointers many times, and runs traffic on both clocks at once, at two unrelated clock periods.

// File: rtl/xdom_fifo_pkg.sv
`timescale 1ns/1ps
package xdom_fifo_pkg;

    typedef enum logic {
        SIDE_OPEN    = 1'b0,
        SIDE_BLOCKED = 1'b1
    } side_st_e;

    // Reflected code of a position in a 2*depth cyclic sequence.
    function automatic int code_at(int pos, int depth, int kbits);
        int low;
        int g;
        int k_const;
        k_const = ((depth - 1) ^ ((depth - 1) >> 1)) | (1 << (kbits - 1));
        low     = (pos >= depth) ? pos - depth : pos;
        g       = low ^ (low >> 1);
        if (pos >= depth) g = g ^ k_const;
        return g;
    endfunction

endpackage

// File: rtl/xdom_sync2.sv
`timescale 1ns/1ps
module xdom_sync2 #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= d;
            stage2_q <= stage1_q;
        end
    end

    assign q = stage2_q;

endmodule

// File: rtl/xdom_ptr_side.sv
`timescale 1ns/1ps
module xdom_ptr_side
    import xdom_fifo_pkg::*;
#(
    parameter int DEPTH    = 5,
    parameter int PTR_W    = 4,
    parameter int AW       = 3,
    parameter bit IS_WRITE = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic [PTR_W-1:0] far_code,
    output logic [PTR_W-1:0] code_q,
    output logic [AW-1:0]    addr,
    output logic             open,
    output logic             fire
);

    localparam int LAST = 2 * DEPTH - 1;
    localparam logic [PTR_W-1:0] LAST_POS  = PTR_W'(LAST);
    localparam logic [PTR_W-1:0] DEPTH_POS = PTR_W'(DEPTH);
    localparam logic [PTR_W-1:0] FULL_CODE = PTR_W'(code_at(DEPTH, DEPTH, PTR_W));

    logic [PTR_W-1:0] pos_q;
    logic [PTR_W-1:0] pos_nx;
    logic [PTR_W-1:0] code_nx;
    logic [PTR_W-1:0] folded;
    logic             blocked;
    side_st_e         state;

    // Next position and its code
    always_comb begin
        pos_nx  = (pos_q == LAST_POS) ? '0 : pos_q + 1'b1;
        code_nx = PTR_W'(code_at(int'(pos_nx), DEPTH, PTR_W));
    end

    // Storage address: position folded into 0..DEPTH-1
    always_comb begin
        folded = (pos_q >= DEPTH_POS) ? pos_q - DEPTH_POS : pos_q;
        addr   = folded[AW-1:0];
    end

    // Full detection on the write side, empty detection on the read side
    generate
        if (IS_WRITE) begin : g_full
            assign blocked = ((code_q ^ far_code) == FULL_CODE);
        end else begin : g_empty
            assign blocked = (code_q == far_code);
        end
    endgenerate

    always_comb state = blocked ? SIDE_BLOCKED : SIDE_OPEN;

    always_comb begin
        unique case (state)
            SIDE_OPEN: begin
                open = 1'b1;
                fire = req;
            end
            SIDE_BLOCKED: begin
                open = 1'b0;
                fire = 1'b0;
            end
        endcase
    end

    // Position counter and registered code
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q  <= '0;
            code_q <= '0;
        end else if (fire) begin
            pos_q  <= pos_nx;
            code_q <= code_nx;
        end
    end

    assert_one_bit_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> ($countones(code_q ^ $past(code_q)) == 1));

    assert_pos_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pos_q <= LAST_POS);

    generate
        if (IS_WRITE) begin : g_chk_wr
            assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (blocked && req) |=> $stable(pos_q));
        end else begin : g_chk_rd
            assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (blocked && req) |=> $stable(pos_q));
        end
    endgenerate

endmodule

// File: rtl/xdom_store.sv
`timescale 1ns/1ps
module xdom_store #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 5,
    parameter int AW     = 3
) (
    input  logic              wr_clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge wr_clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/xdom_fifo.sv
`timescale 1ns/1ps
module xdom_fifo #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 5
) (
    input  logic              wr_clk,
    input  logic              wr_rst_n,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic              rd_clk,
    input  logic              rd_rst_n,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    input  logic              rd_ready
);

    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int PTR_W = AW + 1;

    logic [PTR_W-1:0] wr_code;
    logic [PTR_W-1:0] rd_code;
    logic [PTR_W-1:0] rd_code_in_wr;
    logic [PTR_W-1:0] wr_code_in_rd;
    logic [AW-1:0]    waddr;
    logic [AW-1:0]    raddr;
    logic             wr_fire;
    logic             rd_fire;

    xdom_ptr_side #(
        .DEPTH(DEPTH), .PTR_W(PTR_W), .AW(AW), .IS_WRITE(1'b1)
    ) u_wr_side (
        .clk(wr_clk), .rst_n(wr_rst_n), .req(wr_valid),
        .far_code(rd_code_in_wr), .code_q(wr_code), .addr(waddr),
        .open(wr_ready), .fire(wr_fire)
    );

    xdom_ptr_side #(
        .DEPTH(DEPTH), .PTR_W(PTR_W), .AW(AW), .IS_WRITE(1'b0)
    ) u_rd_side (
        .clk(rd_clk), .rst_n(rd_rst_n), .req(rd_ready),
        .far_code(wr_code_in_rd), .code_q(rd_code), .addr(raddr),
        .open(rd_valid), .fire(rd_fire)
    );

    xdom_sync2 #(.W(PTR_W)) u_rd_to_wr (
        .clk(wr_clk), .rst_n(wr_rst_n), .d(rd_code), .q(rd_code_in_wr)
    );

    xdom_sync2 #(.W(PTR_W)) u_wr_to_rd (
        .clk(rd_clk), .rst_n(rd_rst_n), .d(wr_code), .q(wr_code_in_rd)
    );

    xdom_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW)) u_store (
        .wr_clk(wr_clk), .we(wr_fire), .waddr(waddr), .wdata(wr_data),
        .raddr(raddr), .rdata(rd_data)
    );

    assert_rd_hold_R5: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (!rd_valid && rd_ready) |=> $stable(rd_code));

    assert_wr_hold_R4: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        (!wr_ready && wr_valid) |=> $stable(wr_code));

endmodule

// File: tb/tb_xdom_fifo.sv
`timescale 1ns/1ps
module tb_xdom_fifo;

    localparam int DW = 8;
    localparam int D  = 5;

    logic          wr_clk = 1'b0;
    logic          rd_clk = 1'b0;
    logic          wr_rst_n = 1'b0;
    logic          rd_rst_n = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          wr_valid = 1'b0;
    logic          wr_ready;
    logic [DW-1:0] rd_data;
    logic          rd_valid;
    logic          rd_ready = 1'b0;

    int            n_vec = 0;
    int            n_bad = 0;
    bit            done = 1'b0;
    logic [DW-1:0] model[$];

    always #5 wr_clk = ~wr_clk;
    always #7 rd_clk = ~rd_clk;

    xdom_fifo #(.DATA_W(DW), .DEPTH(D)) dut (
        .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_data(wr_data),
        .wr_valid(wr_valid), .wr_ready(wr_ready),
        .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_data(rd_data),
        .rd_valid(rd_valid), .rd_ready(rd_ready)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic push(input logic [DW-1:0] d);
        @(negedge wr_clk);
        wr_valid = 1'b1;
        wr_data  = d;
        while (!wr_ready) @(negedge wr_clk);
        @(posedge wr_clk);
        model.push_back(d);
        #1 wr_valid = 1'b0;
    endtask

    task automatic pop(input string req);
        logic [DW-1:0] exp;
        @(negedge rd_clk);
        rd_ready = 1'b1;
        while (!rd_valid) @(negedge rd_clk);
        if (model.size() == 0) begin
            check(1'b0, req, int'(rd_data), -1);
        end else begin
            exp = model.pop_front();
            check(rd_data == exp, req, int'(rd_data), int'(exp));
        end
        @(posedge rd_clk);
        #1 rd_ready = 1'b0;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge rd_clk);
        @(negedge wr_clk) wr_rst_n = 1'b1;
        @(negedge rd_clk) rd_rst_n = 1'b1;
        repeat (2) @(negedge wr_clk);

        // R1: state after reset
        check(wr_ready == 1'b1, "R1", int'(wr_ready), 1);
        check(rd_valid == 1'b0, "R1", int'(rd_valid), 0);

        // R5: reads on empty are ignored
        @(negedge rd_clk) rd_ready = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(negedge rd_clk);
            check(rd_valid == 1'b0, "R5", int'(rd_valid), 0);
        end
        rd_ready = 1'b0;
        push(8'hA5);
        pop("R5");

        // R7: latency of a write into an empty FIFO
        push(8'h3C);
        check(rd_valid == 1'b0, "R7", int'(rd_valid), 0);
        repeat (3) @(posedge rd_clk);
        #1 check(rd_valid == 1'b1, "R7", int'(rd_valid), 1);
        pop("R7");

        // R3: capacity with reads stalled
        for (int i = 0; i < D; i++) push(8'(8'h10 + i));
        repeat (4) @(negedge wr_clk);
        check(wr_ready == 1'b0, "R3", int'(wr_ready), 0);
        check(model.size() == D, "R3", model.size(), D);

        // R4: writes while full are refused
        @(negedge wr_clk);
        wr_valid = 1'b1;
        wr_data  = 8'hEE;
        for (int i = 0; i < 5; i++) begin
            @(negedge wr_clk);
            check(wr_ready == 1'b0, "R4", int'(wr_ready), 0);
        end
        wr_valid = 1'b0;

        // R8: ready returns only after the read pointer crosses back
        pop("R6");
        check(wr_ready == 1'b0, "R8", int'(wr_ready), 0);
        repeat (3) @(posedge wr_clk);
        #1 check(wr_ready == 1'b1, "R8", int'(wr_ready), 1);

        for (int i = 1; i < D; i++) pop("R4");
        repeat (6) @(negedge rd_clk);
        check(rd_valid == 1'b0, "R4", int'(rd_valid), 0);

        // R6: sweep all fill levels, several rounds, pointers wrap often
        for (int lvl = 1; lvl <= D; lvl++) begin
            for (int rnd = 0; rnd < 3; rnd++) begin
                for (int i = 0; i < lvl; i++) push(8'(lvl * 16 + rnd * 5 + i));
                for (int i = 0; i < lvl; i++) pop("R6");
            end
        end

        // R6: concurrent traffic on both clocks
        fork
            begin
                for (int i = 0; i < 6 * D + 3; i++) push(8'(8'h80 + i * 7));
            end
            begin
                for (int i = 0; i < 6 * D + 3; i++) pop("R6");
            end
        join
        repeat (6) @(negedge rd_clk);
        check(rd_valid == 1'b0, "R6", int'(rd_valid), 0);
        check(wr_ready == 1'b1, "R6", int'(wr_ready), 1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule